// File: doc/BRIEF.md
# Bead Slot Manager

This block keeps the spatial bookkeeping for a particle simulation pipeline. Space is cut into cells, and every cell owns eight slots, each able to hold the tag of one bead. Three tables hold the map. A slot table stores the bead tag in each slot. A free mask per cell marks the empty slots. A one-hot word per bead names the slot that bead holds. A fourth table stores each bead's state record: position, velocity and time.

Three kinds of traffic arrive at the block. A prediction unit asks for one cell at a time. It gets the occupied-slot mask and the tags one cycle later, and the state records of those beads one cycle after that. A committed collision overwrites a bead's state record. A committed cell crossing gives a bead's new position. The block takes the cell from the top bits of each axis. In a single cycle it puts the bead into the lowest free slot of that cell and empties the slot the bead held before. A crossing into a full cell is refused and raises a sticky error flag.

Top module: `bead_slot_manager`

## Requirements
- R1: After reset every slot of every cell is free. `rd_ptr_vld`, `rd_mask`, `rd_ptrs`, `st_vld`, `st_data` and `xc_err` are all zero.
- R2: A position word carries X in its top POS_W bits, then Y, then Z. The cell index is {X top AXIS_BITS, Y top AXIS_BITS, Z top AXIS_BITS}, with X in the most significant bits.
- R3: An accepted crossing stores the bead tag in the lowest-numbered free slot of the target cell and marks that slot occupied.
- R4: When a bead that holds a slot crosses, its old slot becomes free and its tag there is cleared to zero in the same cycle. This also holds when the target cell is the bead's own cell.
- R5: A crossing into a cell with no free slot is refused. The slot tables, the free masks and the state records are left unchanged.
- R6: `rd_ptr_vld` pulses one cycle after `rd_req`. It comes with `rd_mask` (bit s set means slot s is occupied) and `rd_ptrs` (slot s at bits [s*BEAD_AW +: BEAD_AW], zero for a free slot). `st_vld` pulses one cycle after that. In `st_data`, slot s sits at [s*SW +: SW] with the layout {pos, vel, time}, and a free slot reads zero. All of these outputs hold their value between requests.
- R7: A collision commit replaces the whole state record of `col_bead`.
- R8: A read issued in the same cycle as a crossing returns the tables as they stand after the crossing. A state stage in the same cycle as a collision or crossing write returns the new record.
- R9: `xc_err` is set by a refused crossing and only reset clears it.
- R10: A bead that holds no slot, as after reset, is only inserted by a crossing. No slot is freed.
- R11: An accepted crossing writes its position into the bead's record and keeps velocity and time. A collision on the same bead in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Cell read request |
| rd_cell | input | CELL_AW | Cell to read |
| col_we | input | 1 | Collision commit |
| col_bead | input | BEAD_AW | Bead tag of the collision |
| col_pos | input | 3*POS_W | New position {X,Y,Z} |
| col_vel | input | 3*VEL_W | New velocity |
| col_time | input | TIME_W | New time stamp |
| xc_we | input | 1 | Cell crossing commit |
| xc_bead | input | BEAD_AW | Bead tag of the crossing |
| xc_pos | input | 3*POS_W | Position after the crossing {X,Y,Z} |
| rd_ptr_vld | output | 1 | Slot data valid |
| rd_mask | output | 8 | Occupied slots of the read cell |
| rd_ptrs | output | 8*BEAD_AW | Bead tags per slot |
| st_vld | output | 1 | State data valid |
| st_data | output | 8*SW | State records per slot |
| xc_err | output | 1 | Sticky refused-crossing flag |

## Verification
The assertions check four rules on every cycle. The error flag stays set once raised. A refused crossing leaves the free masks alone. The number of free slots drops by exactly one for a fresh insertion and stays the same for a move. Every bead's slot word is one-hot or zero. They also check that the state stage follows the slot stage by one cycle. Which slot a bead lands in, the tags and state records returned, forwarding within a cycle, and the order of precedence between collision and crossing can only be shown by the bench's scenarios. It compares every output against a behavioural model of cells, slots and records on every clock.

// File: rtl/slotmgr_pkg.sv
package slotmgr_pkg;
  localparam int SLOTS = 8;
  typedef logic [SLOTS-1:0] slot_vec_t;

  // isolate the lowest set bit of a slot mask
  function automatic slot_vec_t lowest_set(input slot_vec_t v);
    return v & (~v + slot_vec_t'(1));
  endfunction
endpackage

// File: rtl/slotmgr_slot_pick.sv
module slotmgr_slot_pick
  import slotmgr_pkg::*;
(
  input  slot_vec_t free_vec,
  output slot_vec_t pick,
  output logic      none
);
  assign pick = lowest_set(free_vec);
  assign none = ~|free_vec;
endmodule

// File: rtl/slotmgr_cell_map.sv
module slotmgr_cell_map
  import slotmgr_pkg::*;
#(
  parameter int CELL_AW = 3,
  parameter int BEAD_AW = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               rd_req,
  input  logic [CELL_AW-1:0]                 rd_cell,
  input  logic                               xc_we,
  input  logic [BEAD_AW-1:0]                 xc_bead,
  input  logic [CELL_AW-1:0]                 xc_cell,
  output logic                               xc_accept,
  output logic                               rd_ptr_vld,
  output slot_vec_t                          rd_mask,
  output logic [SLOTS-1:0][BEAD_AW-1:0]      rd_ptrs,
  output logic                               xc_err
);
  localparam int NCELL = 1 << CELL_AW;
  localparam int NBEAD = 1 << BEAD_AW;

  logic [NCELL-1:0][SLOTS-1:0]              free_q, free_d;
  logic [NCELL-1:0][SLOTS-1:0][BEAD_AW-1:0] ptr_q, ptr_d;
  logic [NBEAD-1:0][SLOTS-1:0]              boh_q;
  logic [NBEAD-1:0][CELL_AW-1:0]            bcell_q;

  slot_vec_t          old_oh, pick;
  logic [CELL_AW-1:0] old_cell;
  logic               placed, no_room;

  assign old_oh   = boh_q[xc_bead];
  assign old_cell = bcell_q[xc_bead];
  assign placed   = |old_oh;

  slotmgr_slot_pick u_pick (
    .free_vec (free_q[xc_cell]),
    .pick     (pick),
    .none     (no_room)
  );

  assign xc_accept = xc_we & ~no_room;

  // next-state tables: release old slot, claim picked slot (distinct bits)
  always_comb begin
    free_d = free_q;
    ptr_d  = ptr_q;
    if (xc_accept) begin
      if (placed) free_d[old_cell] = free_d[old_cell] | old_oh;
      free_d[xc_cell] = free_d[xc_cell] & ~pick;
      for (int s = 0; s < SLOTS; s++) begin
        if (placed && old_oh[s]) ptr_d[old_cell][s] = '0;
        if (pick[s])             ptr_d[xc_cell][s]  = xc_bead;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q     <= '1;
      ptr_q      <= '0;
      boh_q      <= '0;
      bcell_q    <= '0;
      xc_err     <= 1'b0;
      rd_ptr_vld <= 1'b0;
      rd_mask    <= '0;
      rd_ptrs    <= '0;
    end else begin
      free_q <= free_d;
      ptr_q  <= ptr_d;
      if (xc_accept) begin
        boh_q[xc_bead]   <= pick;
        bcell_q[xc_bead] <= xc_cell;
      end
      if (xc_we && no_room) xc_err <= 1'b1;
      rd_ptr_vld <= rd_req;
      if (rd_req) begin
        rd_mask <= ~free_d[rd_cell];
        rd_ptrs <= ptr_d[rd_cell];
      end
    end
  end

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    xc_err |=> xc_err);

  a_r5_reject_keeps_free: assert property (@(posedge clk) disable iff (rst)
    (xc_we && no_room) |=> ($stable(free_q) && xc_err));

  a_r10_fresh_insert_count: assert property (@(posedge clk) disable iff (rst)
    (xc_accept && !placed) |=> ($countones(free_q) == $past($countones(free_q)) - 1));

  a_r4_move_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (xc_accept && placed) |=> ($countones(free_q) == $past($countones(free_q))));

  for (genvar b = 0; b < NBEAD; b++) begin : g_bead_chk
    a_r3_slot_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(boh_q[b]));
  end
endmodule

// File: rtl/slotmgr_bead_store.sv
module slotmgr_bead_store
  import slotmgr_pkg::*;
#(
  parameter int BEAD_AW = 4,
  parameter int PW      = 24,
  parameter int SW      = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          col_we,
  input  logic [BEAD_AW-1:0]            col_bead,
  input  logic [SW-1:0]                 col_state,
  input  logic                          xc_accept,
  input  logic [BEAD_AW-1:0]            xc_bead,
  input  logic [PW-1:0]                 xc_pos,
  input  logic                          ptr_vld,
  input  slot_vec_t                     ptr_mask,
  input  logic [SLOTS-1:0][BEAD_AW-1:0] ptrs,
  output logic                          st_vld,
  output logic [SLOTS-1:0][SW-1:0]      st_data
);
  localparam int NBEAD = 1 << BEAD_AW;

  logic [NBEAD-1:0][SW-1:0] mem_q, mem_d;

  // write-first view: crossing updates position, collision overrides all
  always_comb begin
    mem_d = mem_q;
    if (xc_accept) mem_d[xc_bead][SW-1:SW-PW] = xc_pos;
    if (col_we)    mem_d[col_bead] = col_state;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q  <= '0;
      st_vld <= 1'b0;
    end else begin
      mem_q  <= mem_d;
      st_vld <= ptr_vld;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)          st_data[s] <= '0;
      else if (ptr_vld) st_data[s] <= ptr_mask[s] ? mem_d[ptrs[s]] : '0;
    end
  end

  a_r6_state_follows: assert property (@(posedge clk) disable iff (rst)
    ptr_vld |=> st_vld);

  a_r6_state_quiet: assert property (@(posedge clk) disable iff (rst)
    !ptr_vld |=> !st_vld);
endmodule

// File: rtl/bead_slot_manager.sv
module bead_slot_manager
  import slotmgr_pkg::*;
#(
  parameter int POS_W     = 8,
  parameter int AXIS_BITS = 1,
  parameter int BEAD_AW   = 4,
  parameter int VEL_W     = 8,
  parameter int TIME_W    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_req,
  input  logic [3*AXIS_BITS-1:0]       rd_cell,
  input  logic                         col_we,
  input  logic [BEAD_AW-1:0]           col_bead,
  input  logic [3*POS_W-1:0]           col_pos,
  input  logic [3*VEL_W-1:0]           col_vel,
  input  logic [TIME_W-1:0]            col_time,
  input  logic                         xc_we,
  input  logic [BEAD_AW-1:0]           xc_bead,
  input  logic [3*POS_W-1:0]           xc_pos,
  output logic                         rd_ptr_vld,
  output logic [7:0]                   rd_mask,
  output logic [8*BEAD_AW-1:0]         rd_ptrs,
  output logic                         st_vld,
  output logic [8*(3*POS_W+3*VEL_W+TIME_W)-1:0] st_data,
  output logic                         xc_err
);
  localparam int CELL_AW = 3 * AXIS_BITS;
  localparam int PW      = 3 * POS_W;
  localparam int SW      = PW + 3 * VEL_W + TIME_W;

  logic [CELL_AW-1:0]            xc_cell;
  logic                          xc_accept;
  slot_vec_t                     mask_w;
  logic [SLOTS-1:0][BEAD_AW-1:0] ptrs_w;
  logic [SLOTS-1:0][SW-1:0]      st_w;

  // cell index from the top bits of each axis, X most significant
  assign xc_cell = {xc_pos[PW-1 -: AXIS_BITS],
                    xc_pos[2*POS_W-1 -: AXIS_BITS],
                    xc_pos[POS_W-1 -: AXIS_BITS]};

  slotmgr_cell_map #(.CELL_AW(CELL_AW), .BEAD_AW(BEAD_AW)) u_map (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .rd_cell    (rd_cell),
    .xc_we      (xc_we),
    .xc_bead    (xc_bead),
    .xc_cell    (xc_cell),
    .xc_accept  (xc_accept),
    .rd_ptr_vld (rd_ptr_vld),
    .rd_mask    (mask_w),
    .rd_ptrs    (ptrs_w),
    .xc_err     (xc_err)
  );

  slotmgr_bead_store #(.BEAD_AW(BEAD_AW), .PW(PW), .SW(SW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .col_we    (col_we),
    .col_bead  (col_bead),
    .col_state ({col_pos, col_vel, col_time}),
    .xc_accept (xc_accept),
    .xc_bead   (xc_bead),
    .xc_pos    (xc_pos),
    .ptr_vld   (rd_ptr_vld),
    .ptr_mask  (mask_w),
    .ptrs      (ptrs_w),
    .st_vld    (st_vld),
    .st_data   (st_w)
  );

  assign rd_mask = mask_w;
  assign rd_ptrs = ptrs_w;
  assign st_data = st_w;
endmodule

// File: tb/sim_bead_slot_manager.sv
`timescale 1ns/1ps
module sim_bead_slot_manager;
  localparam int WD_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rst;
  logic         rd_req;
  logic [2:0]   rd_cell;
  logic         col_we;
  logic [3:0]   col_bead;
  logic [23:0]  col_pos;
  logic [23:0]  col_vel;
  logic [15:0]  col_time;
  logic         xc_we;
  logic [3:0]   xc_bead;
  logic [23:0]  xc_pos;
  logic         rd_ptr_vld;
  logic [7:0]   rd_mask;
  logic [31:0]  rd_ptrs;
  logic         st_vld;
  logic [511:0] st_data;
  logic         xc_err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bead_slot_manager u0 (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_cell(rd_cell),
    .col_we(col_we), .col_bead(col_bead), .col_pos(col_pos), .col_vel(col_vel),
    .col_time(col_time), .xc_we(xc_we), .xc_bead(xc_bead), .xc_pos(xc_pos),
    .rd_ptr_vld(rd_ptr_vld), .rd_mask(rd_mask), .rd_ptrs(rd_ptrs),
    .st_vld(st_vld), .st_data(st_data), .xc_err(xc_err)
  );

  // behavioural reference
  logic [7:0]   mfree [8];
  logic [3:0]   mptr  [8][8];
  int           mslot [16];
  int           mcell [16];
  logic [63:0]  mst   [16];
  logic         m_rv, m_sv, m_err;
  logic [7:0]   m_rm;
  logic [31:0]  m_rp;
  logic [511:0] m_sd;

  task automatic chk(input string tag, input string what, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 8; c++) begin
      mfree[c] = 8'hFF;
      for (int s = 0; s < 8; s++) mptr[c][s] = 4'd0;
    end
    for (int b = 0; b < 16; b++) begin
      mslot[b] = -1; mcell[b] = 0; mst[b] = 64'd0;
    end
    m_rv = 0; m_sv = 0; m_err = 0; m_rm = 0; m_rp = 0; m_sd = 0;
  endtask

  task automatic model_step();
    logic        prv;
    logic [7:0]  prm;
    logic [31:0] prp;
    logic [2:0]  nc;
    int          pk;
    int          b;
    logic        acc;
    prv = m_rv; prm = m_rm; prp = m_rp;
    nc  = {xc_pos[23], xc_pos[15], xc_pos[7]};
    pk  = -1;
    for (int s = 0; s < 8; s++) if (mfree[nc][s] && pk < 0) pk = s;
    acc = xc_we && (pk >= 0);
    b   = int'(xc_bead);
    if (acc) mst[b][63:40] = xc_pos;
    if (col_we) mst[col_bead] = {col_pos, col_vel, col_time};
    m_sv = prv;
    if (prv)
      for (int s = 0; s < 8; s++)
        m_sd[s*64 +: 64] = prm[s] ? mst[prp[s*4 +: 4]] : 64'd0;
    if (xc_we && pk < 0) m_err = 1'b1;
    if (acc) begin
      if (mslot[b] >= 0) begin
        mfree[mcell[b]][mslot[b]] = 1'b1;
        mptr[mcell[b]][mslot[b]]  = 4'd0;
      end
      mfree[nc][pk] = 1'b0;
      mptr[nc][pk]  = xc_bead;
      mslot[b] = pk;
      mcell[b] = int'(nc);
    end
    m_rv = rd_req;
    if (rd_req) begin
      m_rm = ~mfree[rd_cell];
      for (int s = 0; s < 8; s++) m_rp[s*4 +: 4] = mptr[rd_cell][s];
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    if (rst) model_reset();
    else     model_step();
    #1;
    chk(tag, "rd_ptr_vld", 512'(rd_ptr_vld), 512'(m_rv));
    chk(tag, "rd_mask",    512'(rd_mask),    512'(m_rm));
    chk(tag, "rd_ptrs",    512'(rd_ptrs),    512'(m_rp));
    chk(tag, "st_vld",     512'(st_vld),     512'(m_sv));
    chk(tag, "st_data",    st_data,          m_sd);
    chk(tag, "xc_err",     512'(xc_err),     512'(m_err));
  endtask

  function automatic logic [23:0] mkpos(input int c);
    logic [23:0] p;
    p = 24'($urandom);
    p[23] = c[2]; p[15] = c[1]; p[7] = c[0];
    return p;
  endfunction

  task automatic drive(input logic rr, input int rc, input logic xw, input int xb,
                       input int xcell, input logic cw, input int cb);
    rd_req   = rr;
    rd_cell  = rc[2:0];
    xc_we    = xw;
    xc_bead  = xb[3:0];
    xc_pos   = mkpos(xcell);
    col_we   = cw;
    col_bead = cb[3:0];
    col_pos  = 24'($urandom);
    col_vel  = 24'($urandom);
    col_time = 16'($urandom);
  endtask

  initial begin
    #(WD_CYCLES * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] cd;
    logic [23:0] p7;
    model_reset();
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0);
    cyc("R1"); cyc("R1");
    rst = 1'b0;
    cyc("R1");
    chk("R1", "reset mask", 512'(rd_mask), 512'(0));
    chk("R1", "reset err", 512'(xc_err), 512'(0));
    drive(1, 0, 0, 0, 0, 0, 0); cyc("R1");
    chk("R1", "empty cell mask", 512'(rd_mask), 512'(0));

    // R10 / R2: fresh bead 0 into cell 5 (X=1,Y=0,Z=1)
    drive(0, 0, 1, 0, 5, 0, 0); cyc("R10");
    drive(1, 5, 0, 0, 0, 0, 0); cyc("R2");
    chk("R2", "cell5 mask", 512'(rd_mask), 512'(8'h01));
    chk("R6", "ptr valid", 512'(rd_ptr_vld), 512'(1));
    drive(0, 0, 0, 0, 0, 0, 0); cyc("R6");
    chk("R6", "state valid", 512'(st_vld), 512'(1));

    // R3: two more beads fill slots 1 and 2
    drive(0, 0, 1, 1, 5, 0, 0); cyc("R3");
    drive(0, 0, 1, 2, 5, 0, 0); cyc("R3");
    drive(1, 5, 0, 0, 0, 0, 0); cyc("R3");
    chk("R3", "mask", 512'(rd_mask), 512'(8'h07));
    chk("R3", "ptrs", 512'(rd_ptrs[11:0]), 512'(12'h210));

    // R7: collision on bead 2, then read its record
    drive(0, 0, 0, 0, 0, 1, 2); cd = {col_pos, col_vel, col_time}; cyc("R7");
    drive(1, 5, 0, 0, 0, 0, 0); cyc("R7");
    drive(0, 0, 0, 0, 0, 0, 0); cyc("R7");
    chk("R7", "record slot2", 512'(st_data[2*64 +: 64]), 512'(cd));

    // R4 / R8: bead 1 leaves cell 5 while cell 5 is read
    drive(1, 5, 1, 1, 2, 0, 0); cyc("R8");
    chk("R8", "mask after move", 512'(rd_mask), 512'(8'h05));
    chk("R4", "old slot nulled", 512'(rd_ptrs[7:4]), 512'(0));

    // R3: bead 4 takes the freed lowest slot 1
    drive(1, 5, 1, 4, 5, 0, 0); cyc("R3");
    chk("R3", "refill slot1", 512'(rd_ptrs[7:4]), 512'(4));
    chk("R3", "refill mask", 512'(rd_mask), 512'(8'h07));

    // R4: bead 0 moves within cell 5 -> slot 3, slot 0 freed
    drive(1, 5, 1, 0, 5, 0, 0); p7 = xc_pos; cyc("R4");
    chk("R4", "same cell move", 512'(rd_mask), 512'(8'h0E));

    // R8: collision on bead 4 during the state stage
    drive(1, 5, 0, 0, 0, 0, 0); cyc("R8");
    drive(0, 0, 0, 0, 0, 1, 4); cd = {col_pos, col_vel, col_time}; cyc("R8");
    chk("R8", "forwarded record", 512'(st_data[1*64 +: 64]), 512'(cd));
    chk("R11", "crossing position", 512'(st_data[3*64 +: 64]), 512'({p7, 40'd0}));

    // R11: crossing and collision on bead 2 together
    drive(0, 0, 1, 2, 6, 1, 2); cd = {col_pos, col_vel, col_time}; cyc("R11");
    drive(1, 6, 0, 0, 0, 0, 0); cyc("R11");
    drive(0, 0, 0, 0, 0, 0, 0); cyc("R11");
    chk("R11", "collision wins", 512'(st_data[63:0]), 512'(cd));

    // R5 / R9: fill cell 7, then refuse bead 13
    for (int b = 5; b < 13; b++) begin
      drive(0, 0, 1, b, 7, 0, 0); cyc("R5");
    end
    drive(1, 7, 1, 13, 7, 0, 0); cyc("R5");
    chk("R5", "full mask", 512'(rd_mask), 512'(8'hFF));
    chk("R5", "full ptrs", 512'(rd_ptrs), 512'(32'hCBA98765));
    chk("R9", "err set", 512'(xc_err), 512'(1));
    drive(1, 1, 1, 13, 1, 0, 0); cyc("R10");
    chk("R10", "refused bead unplaced", 512'(rd_mask), 512'(8'h01));
    drive(1, 7, 0, 0, 0, 0, 0); cyc("R5");
    chk("R5", "cell7 unchanged", 512'(rd_ptrs), 512'(32'hCBA98765));
    chk("R9", "err held", 512'(xc_err), 512'(1));

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      drive(1'($urandom), int'($urandom % 8), ($urandom % 3) == 0, int'($urandom % 16),
            int'($urandom % 8), ($urandom % 3) == 0, int'($urandom % 16));
      cyc("R8");
    end

    rst = 1'b1; drive(0, 0, 0, 0, 0, 0, 0); cyc("R9");
    rst = 1'b0; cyc("R9");
    chk("R9", "err cleared by reset", 512'(xc_err), 512'(0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule